// File: doc/BRIEF.md
# Keypad Message Character Editor

This block edits one fixed-length text message held in an external message store, one character at a time, driven by 8-bit command codes from a keypad link. A start strobe carries the index of the message slot to edit. The block then enters edit mode, turns the display cursor on and homes it. From that point it keeps a cursor position inside the message.

Two keys step the character under the cursor up or down through the printable range from space to lower-case z, wrapping at either end. Two other keys move the cursor, which stops at the first and last cells. A final key leaves edit mode.

Each character change reads the current cell from the store, writes the stepped value back, and asks the display to draw the new character and then step its cursor back over the edited cell. Every store write and display command is a request held until its acknowledge. The block accepts no new key while a request is still open.

Top module: `mce_char_editor`

## Requirements
- R1: While reset is applied and after it is released, `editing_o`, `key_ready_o`, `wr_req_o` and `disp_req_o` are low.
- R2: A start strobe while not editing latches `slot_i` and sets the cursor to 0. It then issues display command 1 (cursor on), then command 2 (home). After that `editing_o` and `key_ready_o` are high. A start strobe while editing is ignored and keeps the latched slot.
- R3: Key code 0xFD reads the cell under the cursor on `rd_data_i` and writes the stepped value back to the store. A value from 0x20 to 0x79 becomes that value plus one. The value 0x7A, or any value outside 0x20..0x7A, becomes 0x20.
- R4: Key code 0xF6 does the same with a step down. A value from 0x21 to 0x7A becomes that value minus one. The value 0x20, or any value outside the range, becomes 0x7A.
- R5: After the store write of R3/R4 is acknowledged, display command 3 (put character) is issued with the new character on `disp_data_o`. After that, display command 4 (cursor left) is issued.
- R6: Key code 0xF3 moves the cursor one cell left and issues display command 4. At cell 0 it moves nothing and issues no request.
- R7: Key code 0xF9 moves the cursor one cell right and issues display command 5 (cursor right). At cell MSG_LEN-1 it moves nothing and issues no request.
- R8: Key code 0xF8 issues display command 6 (cursor off). Once that command is acknowledged, `editing_o` and `key_ready_o` go low.
- R9: Any other key code is consumed with no request and no change of cursor or slot.
- R10: `key_ready_o` is low while any request is pending. A store request and a display request are never raised together. A request keeps its address, command and data stable until it is acknowledged.
- R11: While not editing, `key_ready_o` stays low and key codes cause no request.
- R12: The store address on `wr_addr_o` and `rd_addr_o` is slot × MSG_LEN + cursor position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Strobe that enters edit mode |
| slot_i | input | SLOT_W | Message slot to edit, sampled with start_i |
| key_valid_i | input | 1 | Key code present |
| key_code_i | input | 8 | Key command code |
| key_ready_o | output | 1 | Key accepted on this cycle when valid |
| editing_o | output | 1 | Edit mode active |
| rd_addr_o | output | ADDR_W | Address of the cell under the cursor |
| rd_data_i | input | 8 | Store contents at rd_addr_o, same cycle |
| wr_req_o | output | 1 | Store write request |
| wr_addr_o | output | ADDR_W | Store write address |
| wr_data_o | output | 8 | Store write character |
| wr_ack_i | input | 1 | Store write acknowledge |
| disp_req_o | output | 1 | Display command request |
| disp_cmd_o | output | 3 | Display command code (1..6) |
| disp_data_o | output | 8 | Character for command 3, else zero |
| disp_ack_i | input | 1 | Display command acknowledge |

## Verification
A wrong cursor position shows on the very next step key as a store write to the wrong address. A clamp fault shows at the same point as an extra cursor-move command to the display. A faulty wrap shows at once as a wrong character on both the store write and the following put-character command. A lost or reordered acknowledge step shows as a missing or misordered display command within the request sequence of that key. It also leaves `key_ready_o` stuck low, so the next key is never taken.

// File: rtl/mce_pkg.sv
package mce_pkg;

    localparam int          CHAR_W   = 8;
    localparam logic [7:0]  CH_FIRST = 8'h20;
    localparam logic [7:0]  CH_LAST  = 8'h7A;

    localparam logic [7:0]  KC_UP    = 8'hFD;
    localparam logic [7:0]  KC_DOWN  = 8'hF6;
    localparam logic [7:0]  KC_LEFT  = 8'hF3;
    localparam logic [7:0]  KC_RIGHT = 8'hF9;
    localparam logic [7:0]  KC_DONE  = 8'hF8;

    typedef enum logic [2:0] {
        ACT_NONE  = 3'd0,
        ACT_UP    = 3'd1,
        ACT_DOWN  = 3'd2,
        ACT_LEFT  = 3'd3,
        ACT_RIGHT = 3'd4,
        ACT_DONE  = 3'd5
    } act_e;

    typedef enum logic [2:0] {
        DC_NONE       = 3'd0,
        DC_CURSOR_ON  = 3'd1,
        DC_HOME       = 3'd2,
        DC_PUT        = 3'd3,
        DC_LEFT       = 3'd4,
        DC_RIGHT      = 3'd5,
        DC_CURSOR_OFF = 3'd6
    } disp_e;

    typedef enum logic [3:0] {
        S_OFF, S_ON, S_HOME, S_IDLE, S_STORE,
        S_PUT, S_BACK, S_MV_L, S_MV_R, S_EXIT
    } state_e;

    function automatic act_e key_to_act(input logic [7:0] code);
        case (code)
            KC_UP:    return ACT_UP;
            KC_DOWN:  return ACT_DOWN;
            KC_LEFT:  return ACT_LEFT;
            KC_RIGHT: return ACT_RIGHT;
            KC_DONE:  return ACT_DONE;
            default:  return ACT_NONE;
        endcase
    endfunction

    function automatic logic [7:0] char_step(input logic [7:0] ch, input logic up);
        if (up)
            return (ch >= CH_LAST || ch < CH_FIRST) ? CH_FIRST : ch + 8'd1;
        else
            return (ch <= CH_FIRST || ch > CH_LAST) ? CH_LAST : ch - 8'd1;
    endfunction

endpackage

// File: rtl/mce_key_decode.sv
module mce_key_decode
    import mce_pkg::*;
(
    input  logic       valid_i,
    input  logic [7:0] code_i,
    output act_e       act_o
);
    always_comb begin
        act_o = valid_i ? key_to_act(code_i) : ACT_NONE;
    end
endmodule

// File: rtl/mce_cursor.sv
module mce_cursor #(
    parameter int MSG_LEN = 16,
    localparam int POS_W  = $clog2(MSG_LEN)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr_i,
    input  logic             dec_i,
    input  logic             inc_i,
    output logic [POS_W-1:0] pos_o,
    output logic             at_first_o,
    output logic             at_last_o
);
    localparam logic [POS_W-1:0] LAST = POS_W'(MSG_LEN - 1);

    logic [POS_W-1:0] pos_q;

    always_ff @(posedge clk) begin
        if (rst)
            pos_q <= '0;
        else if (clr_i)
            pos_q <= '0;
        else if (dec_i && pos_q != '0)
            pos_q <= pos_q - 1'b1;
        else if (inc_i && pos_q != LAST)
            pos_q <= pos_q + 1'b1;
    end

    assign pos_o      = pos_q;
    assign at_first_o = (pos_q == '0);
    assign at_last_o  = (pos_q == LAST);
endmodule

// File: rtl/mce_seq.sv
module mce_seq
    import mce_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  start_i,
    input  logic  key_valid_i,
    input  act_e  act_i,
    input  logic  at_first_i,
    input  logic  at_last_i,
    input  logic  wr_ack_i,
    input  logic  disp_ack_i,
    output logic  key_ready_o,
    output logic  editing_o,
    output logic  wr_req_o,
    output logic  disp_req_o,
    output disp_e disp_cmd_o,
    output logic  slot_load_o,
    output logic  cur_clr_o,
    output logic  cur_dec_o,
    output logic  cur_inc_o,
    output logic  char_load_o
);
    state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (rst) state_q <= S_OFF;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d     = state_q;
        slot_load_o = 1'b0;
        cur_clr_o   = 1'b0;
        cur_dec_o   = 1'b0;
        cur_inc_o   = 1'b0;
        char_load_o = 1'b0;
        wr_req_o    = 1'b0;
        disp_req_o  = 1'b0;
        disp_cmd_o  = DC_NONE;
        key_ready_o = 1'b0;
        case (state_q)
            S_OFF: begin
                if (start_i) begin
                    slot_load_o = 1'b1;
                    cur_clr_o   = 1'b1;
                    state_d     = S_ON;
                end
            end
            S_ON: begin
                disp_req_o = 1'b1;
                disp_cmd_o = DC_CURSOR_ON;
                if (disp_ack_i) state_d = S_HOME;
            end
            S_HOME: begin
                disp_req_o = 1'b1;
                disp_cmd_o = DC_HOME;
                if (disp_ack_i) state_d = S_IDLE;
            end
            S_IDLE: begin
                key_ready_o = 1'b1;
                if (key_valid_i) begin
                    case (act_i)
                        ACT_UP, ACT_DOWN: begin
                            char_load_o = 1'b1;
                            state_d     = S_STORE;
                        end
                        ACT_LEFT: begin
                            if (!at_first_i) begin
                                cur_dec_o = 1'b1;
                                state_d   = S_MV_L;
                            end
                        end
                        ACT_RIGHT: begin
                            if (!at_last_i) begin
                                cur_inc_o = 1'b1;
                                state_d   = S_MV_R;
                            end
                        end
                        ACT_DONE: state_d = S_EXIT;
                        default:  state_d = S_IDLE;
                    endcase
                end
            end
            S_STORE: begin
                wr_req_o = 1'b1;
                if (wr_ack_i) state_d = S_PUT;
            end
            S_PUT: begin
                disp_req_o = 1'b1;
                disp_cmd_o = DC_PUT;
                if (disp_ack_i) state_d = S_BACK;
            end
            S_BACK, S_MV_L: begin
                disp_req_o = 1'b1;
                disp_cmd_o = DC_LEFT;
                if (disp_ack_i) state_d = S_IDLE;
            end
            S_MV_R: begin
                disp_req_o = 1'b1;
                disp_cmd_o = DC_RIGHT;
                if (disp_ack_i) state_d = S_IDLE;
            end
            S_EXIT: begin
                disp_req_o = 1'b1;
                disp_cmd_o = DC_CURSOR_OFF;
                if (disp_ack_i) state_d = S_OFF;
            end
            default: state_d = S_OFF;
        endcase
    end

    assign editing_o = (state_q != S_OFF);
endmodule

// File: rtl/mce_char_editor.sv
module mce_char_editor
    import mce_pkg::*;
#(
    parameter int MSG_LEN = 16,
    parameter int SLOTS   = 32,
    localparam int POS_W  = $clog2(MSG_LEN),
    localparam int SLOT_W = $clog2(SLOTS),
    localparam int ADDR_W = SLOT_W + POS_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [SLOT_W-1:0] slot_i,
    input  logic              key_valid_i,
    input  logic [7:0]        key_code_i,
    output logic              key_ready_o,
    output logic              editing_o,
    output logic [ADDR_W-1:0] rd_addr_o,
    input  logic [7:0]        rd_data_i,
    output logic              wr_req_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [7:0]        wr_data_o,
    input  logic              wr_ack_i,
    output logic              disp_req_o,
    output logic [2:0]        disp_cmd_o,
    output logic [7:0]        disp_data_o,
    input  logic              disp_ack_i
);
    act_e              act;
    disp_e             disp_cmd;
    logic              slot_load, cur_clr, cur_dec, cur_inc, char_load;
    logic              at_first, at_last;
    logic [POS_W-1:0]  pos;
    logic [SLOT_W-1:0] slot_q;
    logic [7:0]        new_char_q;
    logic [ADDR_W-1:0] cell_addr;

    mce_key_decode u_dec (
        .valid_i (key_valid_i),
        .code_i  (key_code_i),
        .act_o   (act)
    );

    mce_cursor #(.MSG_LEN(MSG_LEN)) u_cur (
        .clk        (clk),
        .rst        (rst),
        .clr_i      (cur_clr),
        .dec_i      (cur_dec),
        .inc_i      (cur_inc),
        .pos_o      (pos),
        .at_first_o (at_first),
        .at_last_o  (at_last)
    );

    mce_seq u_seq (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start_i),
        .key_valid_i (key_valid_i),
        .act_i       (act),
        .at_first_i  (at_first),
        .at_last_i   (at_last),
        .wr_ack_i    (wr_ack_i),
        .disp_ack_i  (disp_ack_i),
        .key_ready_o (key_ready_o),
        .editing_o   (editing_o),
        .wr_req_o    (wr_req_o),
        .disp_req_o  (disp_req_o),
        .disp_cmd_o  (disp_cmd),
        .slot_load_o (slot_load),
        .cur_clr_o   (cur_clr),
        .cur_dec_o   (cur_dec),
        .cur_inc_o   (cur_inc),
        .char_load_o (char_load)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_q     <= '0;
            new_char_q <= CH_FIRST;
        end else begin
            if (slot_load) slot_q <= slot_i;
            if (char_load) new_char_q <= char_step(rd_data_i, act == ACT_UP);
        end
    end

    assign cell_addr   = ADDR_W'(slot_q) * ADDR_W'(MSG_LEN) + ADDR_W'(pos);
    assign rd_addr_o   = cell_addr;
    assign wr_addr_o   = cell_addr;
    assign wr_data_o   = new_char_q;
    assign disp_cmd_o  = disp_cmd;
    assign disp_data_o = (disp_cmd == DC_PUT) ? new_char_q : 8'h00;
endmodule

module mce_char_editor_chk #(
    parameter int ADDR_W = 9
) (
    input logic              clk,
    input logic              rst,
    input logic              editing_o,
    input logic              key_ready_o,
    input logic              wr_req_o,
    input logic [ADDR_W-1:0] wr_addr_o,
    input logic [7:0]        wr_data_o,
    input logic              wr_ack_i,
    input logic              disp_req_o,
    input logic [2:0]        disp_cmd_o,
    input logic [7:0]        disp_data_o,
    input logic              disp_ack_i
);
    p_ready_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        key_ready_o |-> (!wr_req_o && !disp_req_o));

    p_single_req_r10: assert property (@(posedge clk) disable iff (rst)
        !(wr_req_o && disp_req_o));

    p_wr_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (wr_req_o && !wr_ack_i) |=> (wr_req_o && $stable(wr_addr_o) && $stable(wr_data_o)));

    p_disp_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (disp_req_o && !disp_ack_i) |=> (disp_req_o && $stable(disp_cmd_o) && $stable(disp_data_o)));

    p_store_then_put_r5: assert property (@(posedge clk) disable iff (rst)
        (wr_req_o && wr_ack_i) |=> (disp_req_o && disp_cmd_o == 3'd3 && disp_data_o == $past(wr_data_o)));

    p_put_then_left_r5: assert property (@(posedge clk) disable iff (rst)
        (disp_req_o && disp_ack_i && disp_cmd_o == 3'd3) |=> (disp_req_o && disp_cmd_o == 3'd4));

    p_char_range_r3: assert property (@(posedge clk) disable iff (rst)
        wr_req_o |-> (wr_data_o >= 8'h20 && wr_data_o <= 8'h7A));

    p_exit_r8: assert property (@(posedge clk) disable iff (rst)
        (disp_req_o && disp_ack_i && disp_cmd_o == 3'd6) |=> (!editing_o && !key_ready_o));

    p_off_not_ready_r11: assert property (@(posedge clk) disable iff (rst)
        !editing_o |-> !key_ready_o);

    p_reset_quiet_r1: assert property (@(posedge clk)
        $past(rst) |-> (!editing_o && !wr_req_o && !disp_req_o));
endmodule

bind mce_char_editor mce_char_editor_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .editing_o   (editing_o),
    .key_ready_o (key_ready_o),
    .wr_req_o    (wr_req_o),
    .wr_addr_o   (wr_addr_o),
    .wr_data_o   (wr_data_o),
    .wr_ack_i    (wr_ack_i),
    .disp_req_o  (disp_req_o),
    .disp_cmd_o  (disp_cmd_o),
    .disp_data_o (disp_data_o),
    .disp_ack_i  (disp_ack_i)
);

// File: tb/sim_mce_char_editor.sv
module sim_mce_char_editor;
    localparam int MSG_LEN = 16;
    localparam int SLOTS   = 32;
    localparam int POS_W   = $clog2(MSG_LEN);
    localparam int SLOT_W  = $clog2(SLOTS);
    localparam int ADDR_W  = SLOT_W + POS_W;
    localparam int CELLS   = MSG_LEN * SLOTS;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start_i = 1'b0;
    logic [SLOT_W-1:0] slot_i = '0;
    logic              key_valid_i = 1'b0;
    logic [7:0]        key_code_i = 8'h00;
    logic              key_ready_o, editing_o;
    logic [ADDR_W-1:0] rd_addr_o, wr_addr_o;
    logic [7:0]        rd_data_i, wr_data_o, disp_data_o;
    logic              wr_req_o, wr_ack_i = 1'b0;
    logic              disp_req_o, disp_ack_i = 1'b0;
    logic [2:0]        disp_cmd_o;

    logic [7:0] mem [CELLS];
    logic [7:0] exp_mem [CELLS];
    int exp_pos  = 0;
    int exp_slot = 0;
    int tests = 0;
    int fails = 0;
    int lat   = 0;

    int    q_dcmd[$];
    int    q_ddat[$];
    string q_dtag[$];
    int    q_waddr[$];
    int    q_wdat[$];
    string q_wtag[$];

    always #4 clk = ~clk;

    assign rd_data_i = mem[rd_addr_o];

    mce_char_editor #(.MSG_LEN(MSG_LEN), .SLOTS(SLOTS)) u0 (
        .clk(clk), .rst(rst), .start_i(start_i), .slot_i(slot_i),
        .key_valid_i(key_valid_i), .key_code_i(key_code_i),
        .key_ready_o(key_ready_o), .editing_o(editing_o),
        .rd_addr_o(rd_addr_o), .rd_data_i(rd_data_i),
        .wr_req_o(wr_req_o), .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o), .wr_ack_i(wr_ack_i),
        .disp_req_o(disp_req_o), .disp_cmd_o(disp_cmd_o), .disp_data_o(disp_data_o),
        .disp_ack_i(disp_ack_i)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
        end
    endtask

    function automatic int next_lat();
        lat = (lat + 1) % 4;
        return lat;
    endfunction

    // Store responder and monitor
    initial begin
        forever begin
            @(negedge clk);
            wr_ack_i = 1'b0;
            if (wr_req_o) begin
                repeat (next_lat()) @(negedge clk);
                check(key_ready_o == 1'b0, "R10", "key_ready during store request", key_ready_o, 0);
                if (q_waddr.size() == 0) begin
                    check(1'b0, "R9 R11", "unexpected store write addr", wr_addr_o, 0);
                end else begin
                    automatic int ea = q_waddr.pop_front();
                    automatic int ed = q_wdat.pop_front();
                    automatic string t = q_wtag.pop_front();
                    check(int'(wr_addr_o) == ea, t, "store address", wr_addr_o, ea);
                    check(int'(wr_data_o) == ed, t, "store data", wr_data_o, ed);
                end
                mem[wr_addr_o] = wr_data_o;
                wr_ack_i = 1'b1;
            end
        end
    end

    // Display responder and monitor
    initial begin
        forever begin
            @(negedge clk);
            disp_ack_i = 1'b0;
            if (disp_req_o) begin
                repeat (next_lat()) @(negedge clk);
                if (q_dcmd.size() == 0) begin
                    check(1'b0, "R9 R11", "unexpected display command", disp_cmd_o, 0);
                end else begin
                    automatic int ec = q_dcmd.pop_front();
                    automatic int ed = q_ddat.pop_front();
                    automatic string t = q_dtag.pop_front();
                    check(int'(disp_cmd_o) == ec, t, "display command", disp_cmd_o, ec);
                    check(int'(disp_data_o) == ed, t, "display data", disp_data_o, ed);
                end
                disp_ack_i = 1'b1;
            end
        end
    end

    task automatic push_disp(input int c, input int d, input string t);
        q_dcmd.push_back(c);
        q_ddat.push_back(d);
        q_dtag.push_back(t);
    endtask

    function automatic int step_model(input int ch, input bit up);
        if (up) begin
            if (ch < 32 || ch >= 122) return 32;
            return ch + 1;
        end
        if (ch <= 32 || ch > 122) return 122;
        return ch - 1;
    endfunction

    task automatic wait_settled(input bit want_edit);
        @(negedge clk);
        while (!((q_dcmd.size() == 0) && (q_waddr.size() == 0) &&
                 (want_edit ? key_ready_o : !editing_o)))
            @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic begin_edit(input int slot, input string t);
        push_disp(1, 0, t);
        push_disp(2, 0, t);
        exp_slot = slot;
        exp_pos  = 0;
        @(negedge clk);
        start_i = 1'b1;
        slot_i  = SLOT_W'(slot);
        @(negedge clk);
        start_i = 1'b0;
        wait_settled(1'b1);
        check(editing_o == 1'b1, t, "editing after start", editing_o, 1);
        check(key_ready_o == 1'b1, t, "ready after start", key_ready_o, 1);
    endtask

    task automatic press(input logic [7:0] code, input string t);
        automatic int a = exp_slot * MSG_LEN + exp_pos;
        while (!key_ready_o) @(negedge clk);
        case (code)
            8'hFD, 8'hF6: begin
                automatic int n = step_model(int'(exp_mem[a]), code == 8'hFD);
                q_waddr.push_back(a);
                q_wdat.push_back(n);
                q_wtag.push_back(t);
                push_disp(3, n, t);
                push_disp(4, 0, t);
                exp_mem[a] = 8'(n);
            end
            8'hF3: if (exp_pos > 0) begin
                exp_pos--;
                push_disp(4, 0, t);
            end
            8'hF9: if (exp_pos < MSG_LEN - 1) begin
                exp_pos++;
                push_disp(5, 0, t);
            end
            8'hF8: push_disp(6, 0, t);
            default: ;
        endcase
        key_valid_i = 1'b1;
        key_code_i  = code;
        @(negedge clk);
        key_valid_i = 1'b0;
        key_code_i  = 8'h00;
        wait_settled(code != 8'hF8);
        check(q_dcmd.size() == 0 && q_waddr.size() == 0, t, "all expected requests issued",
              q_dcmd.size() + q_waddr.size(), 0);
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL R10 watchdog expired: actual hang expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < CELLS; i++) begin
            mem[i] = 8'h41 + 8'(i % 26);
        end
        mem[3*MSG_LEN + 0] = 8'h7A;
        mem[3*MSG_LEN + 1] = 8'h20;
        mem[3*MSG_LEN + 2] = 8'h05;
        mem[3*MSG_LEN + 3] = 8'h90;
        mem[3*MSG_LEN + 15] = 8'h6D;
        mem[31*MSG_LEN + 0] = 8'h21;
        for (int i = 0; i < CELLS; i++) exp_mem[i] = mem[i];

        repeat (3) @(negedge clk);
        check(!editing_o && !key_ready_o && !wr_req_o && !disp_req_o, "R1",
              "outputs during reset", {editing_o, key_ready_o, wr_req_o, disp_req_o}, 0);
        rst = 1'b0;
        @(negedge clk);
        check(!editing_o && !key_ready_o && !wr_req_o && !disp_req_o, "R1",
              "outputs after reset", {editing_o, key_ready_o, wr_req_o, disp_req_o}, 0);

        // R11: keys while not editing
        key_valid_i = 1'b1;
        key_code_i  = 8'hFD;
        repeat (4) begin
            @(negedge clk);
            check(key_ready_o == 1'b0, "R11", "ready while off", key_ready_o, 0);
        end
        key_valid_i = 1'b0;
        repeat (4) @(negedge clk);
        check(!wr_req_o && !disp_req_o, "R11", "no request while off", {wr_req_o, disp_req_o}, 0);

        begin_edit(3, "R2");

        // R2: second start while editing ignored
        @(negedge clk);
        start_i = 1'b1;
        slot_i  = SLOT_W'(7);
        @(negedge clk);
        start_i = 1'b0;
        repeat (4) @(negedge clk);

        press(8'hFD, "R3 R12");   // 'z' wraps to space, slot 3 kept
        press(8'hFD, "R3");       // space -> '!'
        press(8'hF6, "R4");       // '!' -> space
        press(8'hF6, "R4");       // space wraps to 'z'
        press(8'hF3, "R6");       // clamp at cell 0
        press(8'hFD, "R6 R5");    // still cell 0
        press(8'hF9, "R7");
        press(8'hFD, "R3 R5");    // cell 1: space -> '!'
        press(8'hF3, "R6");       // back to cell 0
        press(8'hF9, "R7");
        press(8'hF9, "R7");       // cell 2
        press(8'hFD, "R3");       // 0x05 out of range -> space
        press(8'hF9, "R7");       // cell 3
        press(8'hF6, "R4");       // 0x90 out of range -> 'z'
        press(8'hF0, "R9");
        press(8'h3D, "R9");
        press(8'hFF, "R9");
        press(8'hF6, "R9 R4");    // cursor still at cell 3
        for (int k = 0; k < 15; k++) press(8'hF9, "R7");
        press(8'hF6, "R12");      // cell 15 of slot 3
        press(8'hF8, "R8");
        check(editing_o == 1'b0 && key_ready_o == 1'b0, "R8", "state after exit",
              {editing_o, key_ready_o}, 0);

        begin_edit(31, "R2");
        press(8'hF6, "R2 R12");   // cell 0 of slot 31: '!' -> space
        press(8'hF6, "R4");
        press(8'hF8, "R8");

        for (int i = 0; i < CELLS; i++) begin
            if (mem[i] != exp_mem[i])
                check(1'b0, "R3 R4", "store contents", mem[i], exp_mem[i]);
        end
        check(mem[3*MSG_LEN + 15] == 8'h6C, "R12", "slot 3 last cell", mem[3*MSG_LEN + 15], 8'h6C);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule